// File: doc/BRIEF.md
# Layered Garbled-Gate Dispatcher

This block runs one layer of a garbled Boolean circuit at a time on a fixed set of hardware gate engines. The engines are one free-XOR datapath and a parameterised number of AND units. All wire keys are held in an on-chip key RAM, and a wire's identifier is also its RAM address. The circuit is wired at run time, so the same hardware can evaluate any circuit without being rebuilt. The host writes the circuit-input keys into the RAM first. It then opens a layer by giving its gate count and streams one command per gate. Each command carries two input wire IDs, an output wire ID, a gate-type flag and, for AND gates, the index of the unit that must run it.

For every accepted command the block fetches both input keys. An XOR gate's output key is the bitwise XOR of the two inputs and needs no unit. An AND gate goes to its assigned unit. Here each unit is a stand-in with a configurable fixed latency that returns the bitwise AND of its two keys. Every output key is written back to the RAM at its output wire ID. When the number of write-backs reaches the layer's gate count, the block raises a one-cycle completion pulse and stops taking commands. The host may then read keys back or open the next layer. Within a layer the host places AND gates first and assigns them to units in round-robin order of arrival.

Top module: `gc_layer_dispatch`

## Requirements
- R1: After reset, cmd_ready, layer_done and layer_busy are all low.
- R2: A host write to key_wr_id stores key_wr_val at that wire ID. A read request on key_rd_id returns the stored key on key_rd_val after the next rising clock edge. Layer processing never changes the key of a wire that is not a gate output.
- R3: An accepted command with cmd_is_and = 0 writes in_a_key XOR in_b_key to the wire given by cmd_out.
- R4: An accepted command with cmd_is_and = 1 writes in_a_key AND in_b_key to cmd_out. For a lone AND gate in an otherwise empty pipeline, layer_done is high exactly AND_LAT+1 rising edges after the edge that accepted the command.
- R5: A command can leave the input stage only when its AND unit is idle. While an AND gate waits for a busy unit, cmd_ready stays low.
- R6: When an AND unit and the XOR path both finish in the same cycle, the AND result is written first and the XOR result is held and written in a later cycle. Neither result is lost.
- R7: layer_done is a single-cycle pulse. It comes when the count of written gate outputs equals the layer's gate count, and it ends the layer. Once layer_gates commands have been accepted, cmd_ready stays low.
- R8: A layer opened with a gate count of zero produces its layer_done pulse on the edge after layer_start.
- R9: Commands are accepted only while a layer is active. A layer may use the outputs of every earlier layer as its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_wr_en | input | 1 | Host key write strobe (use only between layers) |
| key_wr_id | input | WID_W | Wire ID for a host key write |
| key_wr_val | input | KEY_W | Key value for a host write |
| key_rd_en | input | 1 | Host key read strobe |
| key_rd_id | input | WID_W | Wire ID for a host read |
| key_rd_val | output | KEY_W | Key returned one edge after the read request |
| layer_start | input | 1 | Opens a layer (ignored while a layer is active) |
| layer_gates | input | CNT_W | Number of gates in the layer being opened |
| cmd_valid | input | 1 | A gate command is present |
| cmd_ready | output | 1 | The block takes the command on this edge |
| cmd_is_and | input | 1 | 1 = AND gate, 0 = XOR gate |
| cmd_unit | input | UNIT_W | AND unit index for AND gates |
| cmd_in_a | input | WID_W | First input wire ID |
| cmd_in_b | input | WID_W | Second input wire ID |
| cmd_out | input | WID_W | Output wire ID |
| layer_done | output | 1 | One-cycle pulse when the layer has completed |
| layer_busy | output | 1 | A layer is in progress |

## Verification
The bound checker checks the following on every cycle:
- layer_done never lasts longer than one cycle, and the layer is closed when it fires.
- cmd_ready is never raised outside an active layer.
- At most one AND unit finishes in any cycle.
- A held XOR result is still held in the cycle after an AND write-back takes the port.

Other properties depend on data and timing across the whole circuit, so only the scenarios can show them. These are:
- The stored key values after a two-layer circuit whose second layer reads the first layer's outputs.
- The exact AND latency.
- The stall when a unit is reused.
- The zero-gate layer.
- That the circuit-input keys are left untouched.

// File: rtl/gc_layer_dispatch.sv
module gc_layer_dispatch #(
  parameter int KEY_W   = 80,
  parameter int WID_W   = 10,
  parameter int NUM_AND = 4,
  parameter int AND_LAT = 82,
  parameter int CNT_W   = 12,
  localparam int DEPTH  = 1 << WID_W,
  localparam int UNIT_W = (NUM_AND > 1) ? $clog2(NUM_AND) : 1,
  localparam int LAT_W  = $clog2(AND_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr_en,
  input  logic [WID_W-1:0]  key_wr_id,
  input  logic [KEY_W-1:0]  key_wr_val,
  input  logic              key_rd_en,
  input  logic [WID_W-1:0]  key_rd_id,
  output logic [KEY_W-1:0]  key_rd_val,
  input  logic              layer_start,
  input  logic [CNT_W-1:0]  layer_gates,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_is_and,
  input  logic [UNIT_W-1:0] cmd_unit,
  input  logic [WID_W-1:0]  cmd_in_a,
  input  logic [WID_W-1:0]  cmd_in_b,
  input  logic [WID_W-1:0]  cmd_out,
  output logic              layer_done,
  output logic              layer_busy
);

  logic [KEY_W-1:0] kmem [DEPTH];

  logic             active;
  logic [CNT_W-1:0] total, acc_cnt, done_cnt;

  logic              s2_v, s2_and;
  logic [UNIT_W-1:0] s2_unit;
  logic [WID_W-1:0]  s2_out;
  logic [KEY_W-1:0]  s2_ka, s2_kb;

  logic [LAT_W-1:0] u_cnt [NUM_AND];
  logic [KEY_W-1:0] u_key [NUM_AND];
  logic [WID_W-1:0] u_out [NUM_AND];
  logic [NUM_AND-1:0] unit_fin, unit_idle;

  logic             xq_v;
  logic [KEY_W-1:0] xq_key;
  logic [WID_W-1:0] xq_out;

  logic             fin_any, s2_adv, accept, eng_we;
  logic [KEY_W-1:0] fin_key, eng_key;
  logic [WID_W-1:0] fin_out, eng_id;
  logic [CNT_W-1:0] done_next;

  always_comb begin
    fin_key = '0;
    fin_out = '0;
    for (int i = 0; i < NUM_AND; i++) begin
      unit_fin[i]  = (u_cnt[i] == LAT_W'(1));
      unit_idle[i] = (u_cnt[i] == '0);
      if (unit_fin[i]) begin
        fin_key = fin_key | u_key[i];
        fin_out = fin_out | u_out[i];
      end
    end
  end

  assign fin_any   = |unit_fin;
  assign s2_adv    = s2_v && (s2_and ? unit_idle[s2_unit] : (!xq_v || !fin_any));
  assign cmd_ready = active && (acc_cnt != total) && (!s2_v || s2_adv);
  assign accept    = cmd_valid && cmd_ready;
  assign eng_we    = fin_any || xq_v;
  assign eng_key   = fin_any ? fin_key : xq_key;
  assign eng_id    = fin_any ? fin_out : xq_out;
  assign done_next = done_cnt + CNT_W'(eng_we);
  assign layer_busy = active;

  always_ff @(posedge clk) begin
    if (eng_we)         kmem[eng_id]    <= eng_key;
    else if (key_wr_en) kmem[key_wr_id] <= key_wr_val;
  end

  always_ff @(posedge clk) begin
    if (key_rd_en) key_rd_val <= kmem[key_rd_id];
    if (accept) begin
      s2_ka <= kmem[cmd_in_a];
      s2_kb <= kmem[cmd_in_b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v    <= 1'b0;
      s2_and  <= 1'b0;
      s2_unit <= '0;
      s2_out  <= '0;
    end else if (accept) begin
      s2_v    <= 1'b1;
      s2_and  <= cmd_is_and;
      s2_unit <= cmd_unit;
      s2_out  <= cmd_out;
    end else if (s2_adv) begin
      s2_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_AND; i++) begin
        u_cnt[i] <= '0;
        u_key[i] <= '0;
        u_out[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_AND; i++) begin
        if (s2_adv && s2_and && (s2_unit == UNIT_W'(i))) begin
          u_cnt[i] <= LAT_W'(AND_LAT);
          u_key[i] <= s2_ka & s2_kb;
          u_out[i] <= s2_out;
        end else if (u_cnt[i] != '0) begin
          u_cnt[i] <= u_cnt[i] - LAT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xq_v   <= 1'b0;
      xq_key <= '0;
      xq_out <= '0;
    end else if (s2_adv && !s2_and) begin
      xq_v   <= 1'b1;
      xq_key <= s2_ka ^ s2_kb;
      xq_out <= s2_out;
    end else if (xq_v && !fin_any) begin
      xq_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      total      <= '0;
      acc_cnt    <= '0;
      done_cnt   <= '0;
      layer_done <= 1'b0;
    end else begin
      layer_done <= 1'b0;
      if (!active) begin
        if (layer_start) begin
          total    <= layer_gates;
          acc_cnt  <= '0;
          done_cnt <= '0;
          if (layer_gates == '0) layer_done <= 1'b1;
          else                   active     <= 1'b1;
        end
      end else begin
        acc_cnt  <= acc_cnt + CNT_W'(accept);
        done_cnt <= done_next;
        if (done_next == total) begin
          active     <= 1'b0;
          layer_done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/gc_layer_dispatch_chk.sv
module gc_layer_dispatch_chk #(
  parameter int NUM_AND = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_ready,
  input logic               layer_done,
  input logic               layer_busy,
  input logic [NUM_AND-1:0] unit_fin,
  input logic               xq_v
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    layer_done |=> !layer_done);

  assert_done_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    layer_done |-> !layer_busy);

  assert_ready_in_layer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> layer_busy);

  assert_single_and_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_fin));

  assert_xor_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|unit_fin) && xq_v) |=> xq_v);

endmodule

bind gc_layer_dispatch gc_layer_dispatch_chk #(.NUM_AND(NUM_AND)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .layer_done(layer_done),
  .layer_busy(layer_busy), .unit_fin(unit_fin), .xq_v(xq_v)
);

// File: tb/gc_layer_dispatch_tb.sv
module gc_layer_dispatch_tb;
  localparam int KEY_W = 80, WID_W = 10, NUM_AND = 4, AND_LAT = 82, CNT_W = 12;
  localparam int UNIT_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic key_wr_en = 0, key_rd_en = 0, layer_start = 0, cmd_valid = 0, cmd_is_and = 0;
  logic [WID_W-1:0] key_wr_id = '0, key_rd_id = '0, cmd_in_a = '0, cmd_in_b = '0, cmd_out = '0;
  logic [KEY_W-1:0] key_wr_val = '0, key_rd_val;
  logic [CNT_W-1:0] layer_gates = '0;
  logic [UNIT_W-1:0] cmd_unit = '0;
  logic cmd_ready, layer_done, layer_busy;

  always #2 clk = ~clk;

  gc_layer_dispatch #(.KEY_W(KEY_W), .WID_W(WID_W), .NUM_AND(NUM_AND),
                      .AND_LAT(AND_LAT), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .key_wr_en(key_wr_en), .key_wr_id(key_wr_id),
    .key_wr_val(key_wr_val), .key_rd_en(key_rd_en), .key_rd_id(key_rd_id),
    .key_rd_val(key_rd_val), .layer_start(layer_start), .layer_gates(layer_gates),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_and(cmd_is_and),
    .cmd_unit(cmd_unit), .cmd_in_a(cmd_in_a), .cmd_in_b(cmd_in_b), .cmd_out(cmd_out),
    .layer_done(layer_done), .layer_busy(layer_busy));

  int checks = 0, errors = 0;
  logic [KEY_W-1:0] ref_mem [1 << WID_W];
  int               exp_id [$];
  logic [KEY_W-1:0] exp_key [$];
  string            exp_tag [$];

  task automatic check(input bit ok, input string tag, input logic [KEY_W-1:0] act,
                       input logic [KEY_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_write(input int id, input logic [KEY_W-1:0] v);
    @(negedge clk);
    key_wr_en = 1; key_wr_id = WID_W'(id); key_wr_val = v;
    ref_mem[id] = v;
    @(negedge clk);
    key_wr_en = 0;
  endtask

  task automatic host_read(input int id, output logic [KEY_W-1:0] v);
    @(negedge clk);
    key_rd_en = 1; key_rd_id = WID_W'(id);
    @(negedge clk);
    key_rd_en = 0;
    v = key_rd_val;
  endtask

  task automatic start_layer(input int n);
    @(negedge clk);
    layer_start = 1; layer_gates = CNT_W'(n);
    @(negedge clk);
    layer_start = 0;
  endtask

  // driver: pushes the expected write-back into the scoreboard
  task automatic send_gate(input bit is_and, input int unit, input int a, input int b,
                           input int o, input string tag, output int stalls);
    exp_id.push_back(o);
    exp_key.push_back(is_and ? (ref_mem[a] & ref_mem[b]) : (ref_mem[a] ^ ref_mem[b]));
    exp_tag.push_back(tag);
    cmd_valid = 1; cmd_is_and = is_and; cmd_unit = UNIT_W'(unit);
    cmd_in_a = WID_W'(a); cmd_in_b = WID_W'(b); cmd_out = WID_W'(o);
    stalls = 0;
    while (!cmd_ready) begin
      stalls++;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!layer_done && cyc < 1000) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
  endtask

  // monitor: pops the scoreboard and compares against stored keys
  task automatic drain();
    logic [KEY_W-1:0] v;
    while (exp_id.size() > 0) begin
      int id = exp_id.pop_front();
      logic [KEY_W-1:0] e = exp_key.pop_front();
      string t = exp_tag.pop_front();
      ref_mem[id] = e;
      host_read(id, v);
      check(v === e, t, v, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int st, cyc;
    logic [KEY_W-1:0] v, k0;
    repeat (3) @(negedge clk);
    check(cmd_ready === 1'b0, "R1 cmd_ready", KEY_W'(cmd_ready), 0);
    check(layer_done === 1'b0, "R1 layer_done", KEY_W'(layer_done), 0);
    check(layer_busy === 1'b0, "R1 layer_busy", KEY_W'(layer_busy), 0);
    rst_n = 1;
    @(negedge clk);
    check(cmd_ready === 1'b0, "R9 no layer no ready", KEY_W'(cmd_ready), 0);

    for (int i = 0; i < 8; i++)
      host_write(i, {$urandom(), $urandom(), 16'(i * 37 + 5)});
    k0 = ref_mem[0];
    host_read(3, v);
    check(v === ref_mem[3], "R2 host readback", v, ref_mem[3]);

    // layer 0: five ANDs round-robin over four units, then two XORs
    start_layer(7);
    send_gate(1, 0, 0, 1, 16, "R4 and w16", st);
    send_gate(1, 1, 2, 3, 17, "R4 and w17", st);
    send_gate(1, 2, 4, 5, 18, "R4 and w18", st);
    send_gate(1, 3, 6, 7, 19, "R4 and w19", st);
    send_gate(1, 0, 0, 7, 20, "R5 and reused unit w20", st);
    send_gate(0, 0, 1, 2, 21, "R6 xor w21", st);
    check(st >= AND_LAT / 2, "R5 stall on busy unit", KEY_W'(st), KEY_W'(AND_LAT / 2));
    send_gate(0, 0, 3, 4, 22, "R6 xor w22", st);
    check(cmd_ready === 1'b0, "R7 ready low after count", KEY_W'(cmd_ready), 0);
    wait_done(cyc);
    check(layer_done === 1'b1, "R7 done layer0", KEY_W'(layer_done), 1);
    @(negedge clk);
    check(layer_done === 1'b0, "R7 done one cycle", KEY_W'(layer_done), 0);
    drain();

    // lone AND latency
    start_layer(1);
    send_gate(1, 1, 16, 17, 30, "R4 and w30", st);
    wait_done(cyc);
    check(cyc == AND_LAT + 1, "R4 latency", KEY_W'(cyc), KEY_W'(AND_LAT + 1));
    drain();

    // layer 1 reads layer-0 outputs
    start_layer(4);
    send_gate(1, 0, 16, 21, 40, "R9 and w40", st);
    send_gate(1, 1, 17, 22, 41, "R9 and w41", st);
    send_gate(0, 0, 18, 20, 42, "R3 xor w42", st);
    send_gate(0, 0, 19, 16, 43, "R3 xor w43", st);
    wait_done(cyc);
    check(layer_done === 1'b1, "R7 done layer1", KEY_W'(layer_done), 1);
    drain();

    // empty layer
    start_layer(0);
    check(layer_done === 1'b1, "R8 empty layer done", KEY_W'(layer_done), 1);
    @(negedge clk);
    check(layer_done === 1'b0, "R8 empty pulse ends", KEY_W'(layer_done), 0);

    host_read(0, v);
    check(v === k0, "R2 input key untouched", v, k0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule